// File: doc/BRIEF.md
# Deflection Protection Supervisor

This block decides when a deflection system must hide the picture and when it must stop the horizontal drive. It watches two supervised quantities that arrive already digitised by external comparators: the high-voltage (EHT) reference, which is checked against a lower and an upper threshold, and the vertical sawtooth fed back from the vertical output stage, which is checked against its own pair of thresholds. A field-rate tick and a flag marking the second half of the field supply the timing. The block runs from the free-running reference oscillator clock, so it keeps working when the line-locked clock is lost.

An EHT level under the lower threshold only blanks. An EHT level over the upper threshold blanks at once and, if it persists, latches a horizontal-protection status bit. A vertical sawtooth outside its window blanks after a short count of fields, unless blanking on this ground is deselected. If the fault lasts a long count of fields, a vertical-protection status bit is latched. Either latched bit kills the horizontal drive until reset. A power-on flag reports every reset and clears when the status is read.

Top module: `defl_prot_sup`

## Requirements
- R1: While `eht_lo` is 1, `cont_blank` is 1 in the same cycle, and `eht_lo` never sets `hp_on` or `drive_kill`, however many field ticks pass.
- R2: While `eht_hi` is 1, `cont_blank` is 1 in the same cycle, before any field tick.
- R3: `hp_on` becomes 1 after the clock edge that samples the EHT_FIELDS-th field tick (default 2) counted while `eht_hi` stays 1 without a break.
- R4: A vertical fault exists only when `vsaw_lo` is 1 with `second_half` 0, or when `vsaw_hi` is 1 with `second_half` 1. `vsaw_hi` in the first half and `vsaw_lo` in the second half are not faults.
- R5: With `blank_sel` 0, `cont_blank` is 1 while a vertical fault persists and at least V_BLANK_FIELDS (default 3) field ticks have been counted during it. With `blank_sel` 1, this condition never blanks.
- R6: `vp_on` becomes 1 after the edge that samples the V_KILL_FIELDS-th field tick (default 65) of an unbroken vertical fault.
- R7: Once `hp_on` or `vp_on` is 1, it stays 1 until reset, and `drive_kill` and `cont_blank` are both 1.
- R8: While `vert_off` is 1, vertical faults are ignored and the vertical field count is cleared, so `vp_on` cannot be set and vertical blanking does not occur.
- R9: `por_flag` is 1 after every reset. It becomes 0 after the edge that samples `status_rd` high, and it stays 0 until the next reset.
- R10: After reset, `drive_kill`, `cont_blank`, `hp_on` and `vp_on` are 0 when all inputs are idle.
- R11: If the fault condition clears for one clock before its timer expires, the field count of that timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eht_lo | input | 1 | EHT reference is below the lower threshold |
| eht_hi | input | 1 | EHT reference is above the upper threshold |
| vsaw_lo | input | 1 | Vertical sawtooth is below the lower threshold |
| vsaw_hi | input | 1 | Vertical sawtooth is above the upper threshold |
| field_tick | input | 1 | One-cycle pulse once per field |
| second_half | input | 1 | 1 during the second half of the field |
| vert_off | input | 1 | Vertical deflection off; disables vertical protection |
| blank_sel | input | 1 | 1 stops vertical faults from forcing blanking |
| status_rd | input | 1 | One-cycle pulse when the status is read |
| drive_kill | output | 1 | Forces the horizontal drive off |
| cont_blank | output | 1 | Requests continuous blanking |
| hp_on | output | 1 | Latched horizontal (EHT) protection status |
| vp_on | output | 1 | Latched vertical protection status |
| por_flag | output | 1 | Reset-detected flag, cleared on read |

## Verification
A wrong field count shows at the ports as blanking or a status bit that arrives one field early or late. The expiry is therefore checked in the exact cycle after the deciding tick, with a check one tick before it. A timer that fails to restart when the fault clears shows up after a broken fault as blanking that comes too soon, within a single tick. A window that is decoded wrongly, or a latch that is not sticky, shows within one clock as blanking on a legal sawtooth or as a drive that comes back on once the fault clears.

// File: rtl/defl_prot_pkg.sv
package defl_prot_pkg;

  typedef struct packed {
    logic eht_over;
    logic eht_under;
    logic vert_bad;
  } prot_cond_t;

  // Vertical window: low level is bad early in the field, high level late.
  function automatic logic vwin_fault(input logic lo, input logic hi,
                                      input logic late);
    return late ? hi : lo;
  endfunction

  function automatic prot_cond_t classify(input logic e_lo, input logic e_hi,
                                          input logic v_lo, input logic v_hi,
                                          input logic late, input logic voff);
    prot_cond_t c;
    c.eht_under = e_lo;
    c.eht_over  = e_hi;
    c.vert_bad  = !voff && vwin_fault(v_lo, v_hi, late);
    return c;
  endfunction

endpackage

// File: rtl/prot_field_timer.sv
module prot_field_timer #(
  parameter int LIMIT = 4,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          expire
);

  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       count <= '0;
    else if (!active)                 count <= '0;
    else if (tick && count != LIM_V)  count <= count + 1'b1;
  end

  assign expire = active && tick && (count == LAST_V);

endmodule

// File: rtl/prot_status.sv
module prot_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_h,
  input  logic set_v,
  input  logic rd,
  output logic hp_on,
  output logic vp_on,
  output logic por_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_on    <= 1'b0;
      vp_on    <= 1'b0;
      por_flag <= 1'b1;
    end else begin
      if (set_h) hp_on <= 1'b1;
      if (set_v) vp_on <= 1'b1;
      if (rd)    por_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/defl_prot_sup.sv
module defl_prot_sup #(
  parameter int EHT_FIELDS     = 2,
  parameter int V_BLANK_FIELDS = 3,
  parameter int V_KILL_FIELDS  = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eht_lo,
  input  logic eht_hi,
  input  logic vsaw_lo,
  input  logic vsaw_hi,
  input  logic field_tick,
  input  logic second_half,
  input  logic vert_off,
  input  logic blank_sel,
  input  logic status_rd,
  output logic drive_kill,
  output logic cont_blank,
  output logic hp_on,
  output logic vp_on,
  output logic por_flag
);
  import defl_prot_pkg::*;

  localparam int ECW = $clog2(EHT_FIELDS + 1);
  localparam int VCW = $clog2(V_KILL_FIELDS + 1);
  localparam logic [VCW-1:0] VBLANK_V = VCW'(V_BLANK_FIELDS);

  prot_cond_t     cond;
  logic           v_fault;
  logic           eht_expire;
  logic           v_expire;
  logic           v_blank;
  logic [ECW-1:0] eht_cnt;
  logic [VCW-1:0] v_cnt;

  assign cond    = classify(eht_lo, eht_hi, vsaw_lo, vsaw_hi, second_half, vert_off);
  assign v_fault = cond.vert_bad;

  prot_field_timer #(.LIMIT(EHT_FIELDS)) u_eht_tmr (
    .clk(clk), .rst_n(rst_n), .active(cond.eht_over), .tick(field_tick),
    .count(eht_cnt), .expire(eht_expire)
  );

  prot_field_timer #(.LIMIT(V_KILL_FIELDS)) u_v_tmr (
    .clk(clk), .rst_n(rst_n), .active(v_fault), .tick(field_tick),
    .count(v_cnt), .expire(v_expire)
  );

  assign v_blank = v_fault && !blank_sel && (v_cnt >= VBLANK_V);

  prot_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_h(eht_expire), .set_v(v_expire),
    .rd(status_rd), .hp_on(hp_on), .vp_on(vp_on), .por_flag(por_flag)
  );

  assign drive_kill = hp_on || vp_on;
  assign cont_blank = cond.eht_under || cond.eht_over || v_blank || drive_kill;

endmodule

// File: rtl/defl_prot_sup_chk.sv
module defl_prot_sup_chk (
  input logic clk,
  input logic rst_n,
  input logic eht_lo,
  input logic eht_hi,
  input logic field_tick,
  input logic vert_off,
  input logic status_rd,
  input logic v_fault,
  input logic cont_blank,
  input logic drive_kill,
  input logic hp_on,
  input logic vp_on,
  input logic por_flag
);

  a_r1_under_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    eht_lo |-> cont_blank);

  a_r2_over_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    eht_hi |-> cont_blank);

  a_r3_hp_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hp_on) |-> $past(eht_hi && field_tick));

  a_r6_vp_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vp_on) |-> $past(v_fault && field_tick));

  a_r7_hp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hp_on |=> hp_on);

  a_r7_vp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    vp_on |=> vp_on);

  a_r7_kill_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    drive_kill |-> cont_blank);

  a_r8_voff_no_vp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vp_on) |-> $past(!vert_off));

  a_r9_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> !por_flag);

  a_r9_por_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !por_flag |=> !por_flag);

endmodule

bind defl_prot_sup defl_prot_sup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eht_lo(eht_lo), .eht_hi(eht_hi),
  .field_tick(field_tick), .vert_off(vert_off), .status_rd(status_rd),
  .v_fault(v_fault), .cont_blank(cont_blank), .drive_kill(drive_kill),
  .hp_on(hp_on), .vp_on(vp_on), .por_flag(por_flag)
);

// File: tb/defl_prot_sup_tb.sv
module defl_prot_sup_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eht_lo = 0, eht_hi = 0, vsaw_lo = 0, vsaw_hi = 0;
  logic field_tick = 0, second_half = 0, vert_off = 0, blank_sel = 0, status_rd = 0;
  logic drive_kill, cont_blank, hp_on, vp_on, por_flag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  defl_prot_sup u_dut (
    .clk(clk), .rst_n(rst_n), .eht_lo(eht_lo), .eht_hi(eht_hi),
    .vsaw_lo(vsaw_lo), .vsaw_hi(vsaw_hi), .field_tick(field_tick),
    .second_half(second_half), .vert_off(vert_off), .blank_sel(blank_sel),
    .status_rd(status_rd), .drive_kill(drive_kill), .cont_blank(cont_blank),
    .hp_on(hp_on), .vp_on(vp_on), .por_flag(por_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    eht_lo = 0; eht_hi = 0; vsaw_lo = 0; vsaw_hi = 0; field_tick = 0;
    second_half = 0; vert_off = 0; blank_sel = 0; status_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // One field tick pulse; returns at the negedge after the sampling edge.
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      field_tick = 1;
      @(negedge clk);
      field_tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R10 drive_kill", drive_kill, 1'b0);
    chk("R10 cont_blank", cont_blank, 1'b0);
    chk("R10 hp_on", hp_on, 1'b0);
    chk("R10 vp_on", vp_on, 1'b0);
    chk("R9 por after reset", por_flag, 1'b1);
  endtask

  task automatic t_por_read();
    do_reset();
    status_rd = 1;
    @(negedge clk);
    status_rd = 0;
    chk("R9 por cleared", por_flag, 1'b0);
    tick(2);
    chk("R9 por stays 0", por_flag, 1'b0);
    do_reset();
    chk("R9 por set again", por_flag, 1'b1);
  endtask

  task automatic t_eht_low();
    do_reset();
    eht_lo = 1;
    #1;
    chk("R1 blank same cycle", cont_blank, 1'b1);
    tick(5);
    chk("R1 no hp", hp_on, 1'b0);
    chk("R1 no kill", drive_kill, 1'b0);
    eht_lo = 0;
    #1;
    chk("R1 blank released", cont_blank, 1'b0);
  endtask

  task automatic t_eht_high();
    do_reset();
    eht_hi = 1;
    #1;
    chk("R2 blank before tick", cont_blank, 1'b1);
    tick(1);
    chk("R3 hp not yet", hp_on, 1'b0);
    eht_hi = 0;
    @(negedge clk);
    chk("R2 blank released", cont_blank, 1'b0);
    eht_hi = 1;
    tick(1);
    chk("R11 eht timer restarted", hp_on, 1'b0);
    tick(1);
    chk("R3 hp set", hp_on, 1'b1);
    chk("R7 kill from hp", drive_kill, 1'b1);
    eht_hi = 0;
    tick(1);
    chk("R7 hp sticky", hp_on, 1'b1);
    chk("R7 blank while killed", cont_blank, 1'b1);
  endtask

  task automatic t_vert_window();
    do_reset();
    second_half = 1; vsaw_lo = 1;
    tick(5);
    chk("R4 low late not fault", cont_blank, 1'b0);
    second_half = 0; vsaw_lo = 0; vsaw_hi = 1;
    tick(5);
    chk("R4 high early not fault", cont_blank, 1'b0);
    vsaw_hi = 0; vsaw_lo = 1;
    tick(2);
    chk("R5 no blank at 2 fields", cont_blank, 1'b0);
    tick(1);
    chk("R5 blank at 3 fields", cont_blank, 1'b1);
    chk("R4 early low is fault", drive_kill, 1'b0);
  endtask

  task automatic t_blank_sel();
    do_reset();
    blank_sel = 1; second_half = 1; vsaw_hi = 1;
    tick(4);
    chk("R5 blank_sel suppresses", cont_blank, 1'b0);
    blank_sel = 0;
    #1;
    chk("R5 blank when deselect cleared", cont_blank, 1'b1);
  endtask

  task automatic t_restart();
    do_reset();
    vsaw_lo = 1;
    tick(2);
    vsaw_lo = 0;
    @(negedge clk);
    vsaw_lo = 1;
    tick(2);
    chk("R11 vertical timer restarted", cont_blank, 1'b0);
    tick(1);
    chk("R11 blank after full count", cont_blank, 1'b1);
  endtask

  task automatic t_vkill();
    do_reset();
    second_half = 1; vsaw_hi = 1;
    tick(64);
    chk("R6 no vp at 64", vp_on, 1'b0);
    chk("R6 no kill at 64", drive_kill, 1'b0);
    tick(1);
    chk("R6 vp at 65", vp_on, 1'b1);
    chk("R7 kill from vp", drive_kill, 1'b1);
    vsaw_hi = 0;
    tick(2);
    chk("R7 vp sticky", vp_on, 1'b1);
    chk("R7 blank while killed", cont_blank, 1'b1);
  endtask

  task automatic t_vert_off();
    do_reset();
    vert_off = 1; vsaw_lo = 1;
    tick(70);
    chk("R8 no vp when off", vp_on, 1'b0);
    chk("R8 no blank when off", cont_blank, 1'b0);
    vert_off = 0;
    tick(1);
    chk("R8 count was cleared", cont_blank, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_por_read();
    t_eht_low();
    t_eht_high();
    t_vert_window();
    t_blank_sel();
    t_restart();
    t_vkill();
    t_vert_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule